// File: doc/BRIEF.md
# Open-Drain Line Direction Arbiter

This block holds the digital control for one half-duplex line that joins a host side to a card side, such as a data or auxiliary line. Each side idles high through a pull-up. The arbiter watches the level of both pads. The first side seen low becomes the driver, and the arbiter then pulls the other pad low so that the low level passes across. Once the driver lets go, the arbiter releases its own pull. It waits until both pads read high, then drives both pads high for a short, fixed number of clocks to charge stray capacitance. After that it returns to idle.

A channel-enable input parks the line. While parked, the host pad is released and the card pad is held low. A parked channel never returns straight to idle. It first waits for both pads to read high and issues a release pulse, so the low level it held on the card pad is never taken for a card start. One instance serves each line, so the data line and two auxiliary lines use three identical copies.

Top module: `odrain_dir_arbiter`

## Requirements
- R1: In idle with both pads high, none of the four drive outputs (`host_pull_lo`, `card_pull_lo`, `host_boost`, `card_boost`) is asserted.
- R2: When the host pad falls first, `card_pull_lo` asserts on the third rising clock edge after the fall, and `host_pull_lo` stays low.
- R3: When the card pad falls first, `host_pull_lo` asserts on the third rising clock edge after the fall, and `card_pull_lo` stays low.
- R4: The pull on the far side is held for as long as the driving pad stays low. It drops on the third rising edge after the driving pad returns high.
- R5: After the pull is dropped, the release pulse starts only once both pads have been read high through the two-stage synchronizers. If either pad is still held low from outside, the channel waits with no drive active.
- R6: If both pads fall in the same sample cycle, the host side wins: `card_pull_lo` asserts and `host_pull_lo` does not.
- R7: The release pulse asserts `host_boost` and `card_boost` together for exactly `BOOST_CYCLES` clocks. It then returns to idle.
- R8: A falling edge on either pad during the release pulse is ignored. It neither shortens the pulse nor starts a pull, provided the pad is high again by the time the pulse ends.
- R9: With `en` low, from the next rising edge `card_pull_lo` is asserted and `host_pull_lo` and both boosts are deasserted. After `en` returns high, the channel drops the card pull, waits for both pads high, issues a release pulse and only then goes idle.
- R10: Synchronous active-high reset puts the channel in the parked state, with only `card_pull_lo` asserted.
- R11: The two pull-low outputs are never asserted together, and no side is pulled low and boosted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Channel enable; low parks the line |
| host_in | input | 1 | Level read back from the host-side pad |
| card_in | input | 1 | Level read back from the card-side pad |
| host_pull_lo | output | 1 | Open-drain pull-down enable for the host pad |
| card_pull_lo | output | 1 | Open-drain pull-down enable for the card pad |
| host_boost | output | 1 | Active pull-up enable for the host pad |
| card_boost | output | 1 | Active pull-up enable for the card pad |

## Verification
A wrong direction state shows up at the ports within one clock. The wrong pull-down asserts three edges after the fall, or no pull asserts at all, and with a modelled open-drain line that either echoes the wrong side or lets the low fail to cross. A timer or release-state fault shows up as a boost pulse that is too short or too long, or that starts while one pad is still held low. A missing ignore window shows up as a pull-down that asserts right after the pulse, following a glitch during it. Each of these is visible at the pad drive outputs within a few cycles of the event that caused it, so each is checked with directed stimulus at exact edge counts.

// File: rtl/oda_pkg.sv
package oda_pkg;

    typedef enum logic [2:0] {
        ST_PARK  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_HOST  = 3'd2,
        ST_CARD  = 3'd3,
        ST_REL   = 3'd4,
        ST_BOOST = 3'd5
    } oda_state_e;

    typedef struct packed {
        logic host_lo;
        logic card_lo;
        logic host_hi;
        logic card_hi;
    } oda_drive_t;

    // Pad drive implied by each channel state.
    function automatic oda_drive_t drive_of(oda_state_e s);
        oda_drive_t d;
        d = '0;
        case (s)
            ST_PARK:  d.card_lo = 1'b1;
            ST_HOST:  d.card_lo = 1'b1;
            ST_CARD:  d.host_lo = 1'b1;
            ST_BOOST: begin
                d.host_hi = 1'b1;
                d.card_hi = 1'b1;
            end
            default:  d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/oda_sync.sv
module oda_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/oda_boost_timer.sv
module oda_boost_timer #(
    parameter int CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic load,
    output logic last
);
    localparam int W = $clog2(CYCLES + 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= W'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == W'(1));
endmodule

// File: rtl/oda_fsm.sv
module oda_fsm
    import oda_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       host_hi,
    input  logic       card_hi,
    input  logic       boost_last,
    output oda_state_e state,
    output logic       boost_load
);
    oda_state_e nxt;

    always_comb begin
        nxt        = state;
        boost_load = 1'b0;
        case (state)
            ST_PARK:  nxt = ST_REL;
            ST_IDLE: begin
                // host side has priority on a simultaneous fall
                if (!host_hi)      nxt = ST_HOST;
                else if (!card_hi) nxt = ST_CARD;
            end
            ST_HOST:  if (host_hi) nxt = ST_REL;
            ST_CARD:  if (card_hi) nxt = ST_REL;
            ST_REL: begin
                if (host_hi && card_hi) begin
                    nxt        = ST_BOOST;
                    boost_load = 1'b1;
                end
            end
            ST_BOOST: if (boost_last) nxt = ST_IDLE;
            default:  nxt = ST_PARK;
        endcase
        if (!en) begin
            nxt        = ST_PARK;
            boost_load = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PARK;
        end else begin
            state <= nxt;
        end
    end
endmodule

// File: rtl/odrain_dir_arbiter.sv
module odrain_dir_arbiter
    import oda_pkg::*;
#(
    parameter int SYNC_STAGES  = 2,
    parameter int BOOST_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic host_in,
    input  logic card_in,
    output logic host_pull_lo,
    output logic card_pull_lo,
    output logic host_boost,
    output logic card_boost
);
    localparam int NSIDE = 2;

    logic [NSIDE-1:0] pad_raw;
    logic [NSIDE-1:0] pad_hi;
    oda_state_e       state;
    logic             boost_load;
    logic             boost_last;
    oda_drive_t       drv;

    assign pad_raw = {card_in, host_in};

    for (genvar g = 0; g < NSIDE; g++) begin : g_sync
        oda_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (pad_raw[g]),
            .q   (pad_hi[g])
        );
    end

    oda_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .host_hi    (pad_hi[0]),
        .card_hi    (pad_hi[1]),
        .boost_last (boost_last),
        .state      (state),
        .boost_load (boost_load)
    );

    oda_boost_timer #(.CYCLES(BOOST_CYCLES)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (!en),
        .load  (boost_load),
        .last  (boost_last)
    );

    assign drv          = drive_of(state);
    assign host_pull_lo = drv.host_lo;
    assign card_pull_lo = drv.card_lo;
    assign host_boost   = drv.host_hi;
    assign card_boost   = drv.card_hi;
endmodule

// File: rtl/odrain_dir_arbiter_chk.sv
module odrain_dir_arbiter_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst,
    input logic en,
    input logic host_in,
    input logic card_in,
    input logic host_pull_lo,
    input logic card_pull_lo,
    input logic host_boost,
    input logic card_boost
);
    // R11
    no_dual_pull_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_pull_lo && card_pull_lo));

    // R11
    pull_boost_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(host_pull_lo && host_boost) && !(card_pull_lo && card_boost));

    // R9
    park_drive_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> card_pull_lo && !host_pull_lo && !host_boost && !card_boost);

    // R7
    boost_pair_chk: assert property (@(posedge clk) disable iff (rst)
        host_boost == card_boost);

    // R8
    boost_exit_chk: assert property (@(posedge clk) disable iff (rst)
        host_boost && en |=> !host_pull_lo && !card_pull_lo);

    if (SYNC_STAGES == 2) begin : g_cause
        // R2
        host_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(card_pull_lo) && $past(en) |-> !$past(host_in, 3));

        // R3
        card_cause_chk: assert property (@(posedge clk) disable iff (rst)
            $rose(host_pull_lo) |-> !$past(card_in, 3));
    end
endmodule

bind odrain_dir_arbiter odrain_dir_arbiter_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .host_in      (host_in),
    .card_in      (card_in),
    .host_pull_lo (host_pull_lo),
    .card_pull_lo (card_pull_lo),
    .host_boost   (host_boost),
    .card_boost   (card_boost)
);

// File: tb/odrain_dir_arbiter_test.sv
`timescale 1ns/1ps
module odrain_dir_arbiter_test;
    localparam int BC = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b0;
    logic host_ext = 1'b0;
    logic card_ext = 1'b0;
    logic host_in, card_in;
    logic host_pull_lo, card_pull_lo, host_boost, card_boost;
    int   n_run  = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    // open-drain pads: low when either party pulls down
    assign host_in = ~(host_ext | host_pull_lo);
    assign card_in = ~(card_ext | card_pull_lo);

    odrain_dir_arbiter #(.SYNC_STAGES(2), .BOOST_CYCLES(BC)) uut (
        .clk(clk), .rst(rst), .en(en),
        .host_in(host_in), .card_in(card_in),
        .host_pull_lo(host_pull_lo), .card_pull_lo(card_pull_lo),
        .host_boost(host_boost), .card_boost(card_boost)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // expected order: {host_pull_lo, card_pull_lo, host_boost, card_boost}
    task automatic chk(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {host_pull_lo, card_pull_lo, host_boost, card_boost};
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: drive=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1; en = 1'b0;
        tick(3);
        chk("R10 reset parks", 4'b0100);
        rst = 1'b0;
        tick(2);
        chk("R9 parked while en low", 4'b0100);
    endtask

    task automatic t_enable;
        en = 1'b1;
        tick(1);  chk("R9 card pull dropped on enable", 4'b0000);
        tick(3);  chk("R9 R7 pulse after enable", 4'b0011);
        tick(5);  chk("R7 pulse last cycle", 4'b0011);
        tick(1);  chk("R1 idle after pulse", 4'b0000);
        tick(4);  chk("R1 idle holds", 4'b0000);
    endtask

    task automatic t_host;
        host_ext = 1'b1;
        tick(2);  chk("R2 no pull before sync latency", 4'b0000);
        tick(1);  chk("R2 card pulled low", 4'b0100);
        tick(10); chk("R4 pull held", 4'b0100);
        host_ext = 1'b0;
        tick(2);  chk("R4 pull still held", 4'b0100);
        tick(1);  chk("R4 pull dropped", 4'b0000);
        tick(2);  chk("R5 no pulse before both read high", 4'b0000);
        tick(1);  chk("R7 pulse start", 4'b0011);
        tick(5);  chk("R7 pulse end cycle", 4'b0011);
        tick(1);  chk("R7 pulse length", 4'b0000);
    endtask

    task automatic t_card;
        card_ext = 1'b1;
        tick(2);  chk("R3 no pull before sync latency", 4'b0000);
        tick(1);  chk("R3 host pulled low", 4'b1000);
        tick(7);  chk("R4 pull held", 4'b1000);
        card_ext = 1'b0;
        tick(3);  chk("R4 pull dropped", 4'b0000);
        tick(3);  chk("R7 pulse start", 4'b0011);
        tick(6);  chk("R1 idle", 4'b0000);
    endtask

    task automatic t_tie;
        host_ext = 1'b1; card_ext = 1'b1;
        tick(3);  chk("R6 R11 host wins tie", 4'b0100);
        host_ext = 1'b0;
        tick(3);  chk("R4 pull dropped", 4'b0000);
        tick(6);  chk("R5 waits while card held low", 4'b0000);
        card_ext = 1'b0;
        tick(2);  chk("R5 waits for sync", 4'b0000);
        tick(1);  chk("R5 R7 pulse after both high", 4'b0011);
        tick(6);  chk("R1 idle", 4'b0000);
    endtask

    task automatic t_ignore;
        host_ext = 1'b1;
        tick(3);
        host_ext = 1'b0;
        tick(6);  chk("R7 pulse start", 4'b0011);
        card_ext = 1'b1;
        tick(1);
        card_ext = 1'b0;
        for (int i = 0; i < 4; i++) begin
            tick(1); chk("R8 pulse not cut by glitch", 4'b0011);
        end
        tick(1);  chk("R8 idle after pulse", 4'b0000);
        for (int i = 0; i < 4; i++) begin
            tick(1); chk("R8 glitch started no pull", 4'b0000);
        end
    endtask

    task automatic t_disable;
        card_ext = 1'b1;
        tick(3);  chk("R3 host pulled low", 4'b1000);
        en = 1'b0;
        tick(1);  chk("R9 park overrides drive", 4'b0100);
        card_ext = 1'b0;
        tick(3);  chk("R9 stays parked", 4'b0100);
        en = 1'b1;
        tick(1);  chk("R9 release on re-enable", 4'b0000);
        tick(3);  chk("R9 pulse before idle", 4'b0011);
        tick(6);  chk("R1 idle after re-enable", 4'b0000);
    endtask

    initial begin
        #1;
        t_reset;
        t_enable;
        t_host;
        t_card;
        t_tie;
        t_ignore;
        t_disable;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule